// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches twenty external input lines and turns selected transitions on them into interrupt requests and event pulses. Each line passes through a two-flop synchronizer. Each line can be armed independently for rising transitions, falling transitions or both. A qualifying transition latches a per-line pending flag. The flag stays set until software clears it by writing a one to it. Software can also raise a line on its own through a trigger register, which makes the line pending exactly as a hardware edge would.

Each line drives a level interrupt request, which is its pending flag qualified by an interrupt enable bit. Each line also drives a one-clock event pulse, qualified by a separate event enable bit, in the cycle its flag is set. Access is through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address.

Changing the edge selection of a line drops whatever that line had pending. A hardware edge that lands in the same cycle as a software clear keeps the line pending, so that event is not lost.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irqOut` and `evtPulse` are 0.
- R2: The configuration registers sit at byte offsets 0x00 (interrupt enable), 0x04 (event enable), 0x08 (rising select) and 0x0C (falling select). Each reads back bits 19:0 as written, and bits 31:20 always read 0.
- R3: When rising select bit x is 1, a 0-to-1 change on `lineIn[x]` sets pending bit x, which reads 1 at offset 0x14 bit x after the third rising clock edge following the change and not before.
- R4: When falling select bit x is 1, a 1-to-0 change on `lineIn[x]` sets pending bit x with the same three-edge latency as R3.
- R5: A transition whose direction is not selected on its line leaves every pending bit at 0.
- R6: `irqOut[x]` is 1 exactly when pending bit x and interrupt enable bit x are both 1.
- R7: Writing 1 to pending bit x at offset 0x14 clears it on that write's edge. Writing 0 leaves it unchanged.
- R8: Writing 1 to trigger bit x at offset 0x10 while it reads 0 sets both trigger bit x and pending bit x on that write's edge. Writing 1 while it already reads 1 produces no new event pulse. The trigger bit is cleared only when its pending bit is cleared.
- R9: A write to offset 0x08 or 0x0C that changes bit x clears pending bit x (and trigger bit x). Rewriting an unchanged value leaves pending bits as they are.
- R10: With event enable bit x set, each hardware edge or software trigger on line x gives a pulse on `evtPulse[x]` that lasts one clock, in the cycle pending bit x becomes set. With event enable bit x clear, no pulse appears.
- R11: If a hardware edge sets pending bit x on the same edge at which a write clears it, the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 5 | Byte offset of the register to read or write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| lineIn | input | 20 | Asynchronous external lines |
| irqOut | output | 20 | Per-line interrupt request (level) |
| evtPulse | output | 20 | Per-line one-clock event pulse |

## Verification
A hardware edge has a latency of three clock edges: two in the synchronizer and one into the pending register. The bench changes a line just after a falling clock edge. It confirms that nothing is pending at the second following falling edge, and it checks pending, request and pulse at the third. It checks again one edge later to see that the pulse has ended. Register writes and software triggers commit on the rising edge inside the write task. Their results are therefore sampled at the next falling edge, as is the collision in which a clear is timed to land on the same edge that sets the line.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam logic [7:0] OFS_IRQ_EN  = 8'h00;
  localparam logic [7:0] OFS_EVT_EN  = 8'h04;
  localparam logic [7:0] OFS_RISE    = 8'h08;
  localparam logic [7:0] OFS_FALL    = 8'h0C;
  localparam logic [7:0] OFS_SOFT    = 8'h10;
  localparam logic [7:0] OFS_PEND    = 8'h14;

  typedef enum logic [2:0] {
    SEL_IRQ_EN,
    SEL_EVT_EN,
    SEL_RISE,
    SEL_FALL,
    SEL_SOFT,
    SEL_PEND,
    SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    wrIrqEn;
    logic    wrEvtEn;
    logic    wrRise;
    logic    wrFall;
    logic    wrSoft;
    logic    wrPend;
    regSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/extint_decode.sv
module extint_decode
  import extint_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       ctl
);

  localparam logic [ADDR_W-1:0] A_IRQ_EN = ADDR_W'(OFS_IRQ_EN);
  localparam logic [ADDR_W-1:0] A_EVT_EN = ADDR_W'(OFS_EVT_EN);
  localparam logic [ADDR_W-1:0] A_RISE   = ADDR_W'(OFS_RISE);
  localparam logic [ADDR_W-1:0] A_FALL   = ADDR_W'(OFS_FALL);
  localparam logic [ADDR_W-1:0] A_SOFT   = ADDR_W'(OFS_SOFT);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);

  regSel_e sel;

  always_comb begin
    case (busAddr)
      A_IRQ_EN: sel = SEL_IRQ_EN;
      A_EVT_EN: sel = SEL_EVT_EN;
      A_RISE:   sel = SEL_RISE;
      A_FALL:   sel = SEL_FALL;
      A_SOFT:   sel = SEL_SOFT;
      A_PEND:   sel = SEL_PEND;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    ctl.rdSel   = sel;
    ctl.wrIrqEn = busWrEn && (sel == SEL_IRQ_EN);
    ctl.wrEvtEn = busWrEn && (sel == SEL_EVT_EN);
    ctl.wrRise  = busWrEn && (sel == SEL_RISE);
    ctl.wrFall  = busWrEn && (sel == SEL_FALL);
    ctl.wrSoft  = busWrEn && (sel == SEL_SOFT);
    ctl.wrPend  = busWrEn && (sel == SEL_PEND);
  end

endmodule

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 20,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/extint_edge.sv
module extint_edge #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] syncIn,
  input  logic [WIDTH-1:0] riseSel,
  input  logic [WIDTH-1:0] fallSel,
  output logic [WIDTH-1:0] edgeHit
);

  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncIn;
  end

  always_comb begin
    edgeHit = ((syncIn & ~prevQ) & riseSel) | ((~syncIn & prevQ) & fallSel);
  end

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_LINES   = 20,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          ctl,
  input  logic [NUM_LINES-1:0] wrVal,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [DATA_W-1:0]    busRdData,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [NUM_LINES-1:0] evtPulse
);

  logic [NUM_LINES-1:0] irqEnQ, evtEnQ, riseQ, fallQ, swQ, pendQ, evtQ;
  logic [NUM_LINES-1:0] lineSync, hwHit;
  logic [NUM_LINES-1:0] swSet, cfgClr, clrMask, setMask;
  logic [NUM_LINES-1:0] rdLines;

  extint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (lineIn),
    .syncOut (lineSync)
  );

  extint_edge #(.WIDTH(NUM_LINES)) u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (lineSync),
    .riseSel (riseQ),
    .fallSel (fallQ),
    .edgeHit (hwHit)
  );

  always_comb begin
    swSet   = ctl.wrSoft ? (wrVal & ~swQ) : '0;
    cfgClr  = (ctl.wrRise ? (wrVal ^ riseQ) : '0)
            | (ctl.wrFall ? (wrVal ^ fallQ) : '0);
    clrMask = (ctl.wrPend ? wrVal : '0) | cfgClr;
    setMask = hwHit | swSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ <= '0;
      evtEnQ <= '0;
      riseQ  <= '0;
      fallQ  <= '0;
      swQ    <= '0;
      pendQ  <= '0;
      evtQ   <= '0;
    end else begin
      if (ctl.wrIrqEn) irqEnQ <= wrVal;
      if (ctl.wrEvtEn) evtEnQ <= wrVal;
      if (ctl.wrRise)  riseQ  <= wrVal;
      if (ctl.wrFall)  fallQ  <= wrVal;
      swQ   <= (swQ | swSet) & ~clrMask;
      pendQ <= (pendQ & ~clrMask) | setMask;
      evtQ  <= setMask & evtEnQ;
    end
  end

  always_comb begin
    case (ctl.rdSel)
      SEL_IRQ_EN: rdLines = irqEnQ;
      SEL_EVT_EN: rdLines = evtEnQ;
      SEL_RISE:   rdLines = riseQ;
      SEL_FALL:   rdLines = fallQ;
      SEL_SOFT:   rdLines = swQ;
      SEL_PEND:   rdLines = pendQ;
      default:    rdLines = '0;
    endcase
    busRdData = DATA_W'(rdLines);
  end

  assign irqOut   = pendQ & irqEnQ;
  assign evtPulse = evtQ;

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_LINES   = 20,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [NUM_LINES-1:0] evtPulse
);

  ctlStrobes_t ctl;

  if (DATA_W > NUM_LINES) begin : g_hi
    logic unusedWrHi;
    assign unusedWrHi = ^busWrData[DATA_W-1:NUM_LINES];
  end

  extint_decode #(.ADDR_W(ADDR_W)) u_dec (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .ctl     (ctl)
  );

  extint_datapath #(
    .NUM_LINES   (NUM_LINES),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrVal     (busWrData[NUM_LINES-1:0]),
    .lineIn    (lineIn),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .evtPulse  (evtPulse)
  );

endmodule

// File: rtl/extint_chk.sv
module extint_chk #(
  parameter int NUM_LINES = 20,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [NUM_LINES-1:0] wrLow,
  input logic [NUM_LINES-1:0] irqOut,
  input logic [NUM_LINES-1:0] evtPulse,
  input logic [NUM_LINES-1:0] pendQ,
  input logic [NUM_LINES-1:0] swQ,
  input logic [NUM_LINES-1:0] hwHit,
  input logic [NUM_LINES-1:0] setMask
);

  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(8'h14);

  // R10
  evt_has_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse & ~pendQ) == '0);

  // R8
  soft_within_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swQ & ~pendQ) == '0);

  // R6
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~pendQ) == '0);

  // R11
  edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hwHit) |=> ((pendQ & $past(hwHit)) == $past(hwHit)));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == PEND_ADDR) |=>
      ((pendQ & $past(wrLow) & ~$past(setMask)) == '0));

endmodule

bind extint_ctrl extint_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .wrLow    (busWrData[NUM_LINES-1:0]),
  .irqOut   (irqOut),
  .evtPulse (evtPulse),
  .pendQ    (u_dp.pendQ),
  .swQ      (u_dp.swQ),
  .hwHit    (u_dp.hwHit),
  .setMask  (u_dp.setMask)
);

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;

  localparam int NL = 20;
  localparam logic [31:0] LMASK = 32'h000F_FFFF;
  localparam logic [4:0] A_IEN = 5'h00, A_EEN = 5'h04, A_RIS = 5'h08,
                         A_FAL = 5'h0C, A_SFT = 5'h10, A_PND = 5'h14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NL-1:0] lineIn = '0;
  logic [NL-1:0] irqOut, evtPulse;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  extint_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .lineIn(lineIn),
    .irqOut(irqOut), .evtPulse(evtPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is just past a falling edge; write commits on the next rising edge
  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic edgeTrial(input int ln, input logic val, input bit armed, input string req);
    logic [31:0] rd, expv;
    expv = armed ? (32'h1 << ln) : 32'h0;
    lineIn[ln] = val;
    @(negedge clk);
    @(negedge clk);
    readReg(A_PND, rd);
    check({req, " not before third edge"}, rd, 32'h0);
    check("R10 no early pulse", 32'(evtPulse), 32'h0);
    @(negedge clk);
    readReg(A_PND, rd);
    check(req, rd, expv);
    check("R10 pulse on edge", 32'(evtPulse), expv);
    check("R6 request follows pending", 32'(irqOut), expv);
    @(negedge clk);
    check("R10 pulse lasts one clock", 32'(evtPulse), 32'h0);
    busWrite(A_PND, LMASK);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int k = 0; k < 6; k++) begin
      readReg(5'(k * 4), rd);
      check("R1 register reset", rd, 32'h0);
    end
    check("R1 irq reset", 32'(irqOut), 32'h0);
    check("R1 evt reset", 32'(evtPulse), 32'h0);

    // R2 readback with reserved bits
    for (int k = 0; k < 4; k++) begin
      logic [31:0] pat;
      pat = 32'hA5C3_0F96 ^ (32'h1111_1111 * k);
      busWrite(5'(k * 4), pat);
      readReg(5'(k * 4), rd);
      check("R2 readback", rd, pat & LMASK);
      busWrite(5'(k * 4), 32'hFFFF_FFFF);
      readReg(5'(k * 4), rd);
      check("R2 reserved bits zero", rd, LMASK);
    end
    busWrite(A_RIS, 32'h0);
    busWrite(A_FAL, 32'h0);
    busWrite(A_PND, LMASK);

    // R3 R4 R5 sweep over every line and every edge selection
    for (int ln = 0; ln < NL; ln++) begin
      for (int c = 0; c < 4; c++) begin
        bit rs, fs;
        rs = c[0]; fs = c[1];
        busWrite(A_RIS, rs ? (32'h1 << ln) : 32'h0);
        busWrite(A_FAL, fs ? (32'h1 << ln) : 32'h0);
        busWrite(A_PND, LMASK);
        edgeTrial(ln, 1'b1, rs, rs ? "R3 rising edge" : "R5 rising ignored");
        edgeTrial(ln, 1'b0, fs, fs ? "R4 falling edge" : "R5 falling ignored");
      end
    end
    busWrite(A_RIS, 32'h0);
    busWrite(A_FAL, 32'h0);
    busWrite(A_PND, LMASK);

    // R8 software trigger
    busWrite(A_SFT, 32'h8);
    check("R10 pulse on soft trigger", 32'(evtPulse), 32'h8);
    readReg(A_PND, rd);  check("R8 soft sets pending", rd, 32'h8);
    readReg(A_SFT, rd);  check("R8 trigger bit held", rd, 32'h8);
    busWrite(A_SFT, 32'h8);
    check("R8 repeat trigger no pulse", 32'(evtPulse), 32'h0);
    busWrite(A_PND, 32'h0);
    readReg(A_PND, rd);  check("R7 write zero keeps pending", rd, 32'h8);
    readReg(A_SFT, rd);  check("R8 trigger kept while pending", rd, 32'h8);
    busWrite(A_PND, 32'h8);
    readReg(A_PND, rd);  check("R7 write one clears", rd, 32'h0);
    readReg(A_SFT, rd);  check("R8 trigger cleared with pending", rd, 32'h0);

    // R9 sensitivity change clears
    busWrite(A_SFT, 32'h20);
    busWrite(A_RIS, 32'h0);
    readReg(A_PND, rd);  check("R9 unchanged rewrite keeps", rd, 32'h20);
    busWrite(A_RIS, 32'h40);
    readReg(A_PND, rd);  check("R9 other line change keeps", rd, 32'h20);
    busWrite(A_FAL, 32'h20);
    readReg(A_PND, rd);  check("R9 own change clears", rd, 32'h0);
    readReg(A_SFT, rd);  check("R9 trigger cleared", rd, 32'h0);
    busWrite(A_RIS, 32'h0);
    busWrite(A_FAL, 32'h0);

    // R11 set wins over simultaneous clear
    busWrite(A_RIS, 32'h80);
    lineIn[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busWrite(A_PND, 32'h80);
    readReg(A_PND, rd);  check("R11 set wins", rd, 32'h80);
    busWrite(A_PND, 32'h80);
    readReg(A_PND, rd);  check("R7 later clear", rd, 32'h0);
    busWrite(A_RIS, 32'h0);
    lineIn[7] = 1'b0;
    repeat (4) @(negedge clk);

    // R6 masking and R10 event enable off
    busWrite(A_IEN, 32'h4);
    busWrite(A_EEN, 32'h0);
    busWrite(A_SFT, 32'h14);
    check("R6 masked request", 32'(irqOut), 32'h4);
    check("R10 disabled no pulse", 32'(evtPulse), 32'h0);
    readReg(A_PND, rd);  check("R8 both pending", rd, 32'h14);
    busWrite(A_PND, 32'h14);
    check("R6 request drops", 32'(irqOut), 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule